// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block turns a per-cycle phase-error measurement into an active-high lock flag for a phase-locked loop. Each phase-detector cycle arrives as a one-clock strobe. The strobe carries an error magnitude, counted in periods of a fast sampling clock. A mode input selects how many clean cycles in a row are needed before lock is declared. A cycle is clean when its error is below the acquisition threshold. The need is three clean cycles with the mode at 0 and five with the mode at 1.

Once declared, lock has hysteresis. It is released only by a single cycle whose error exceeds a second, larger threshold. Errors between the two thresholds leave lock as it is. Releasing lock discards all progress, so the full run of clean cycles must be seen again before lock returns. The thresholds and the two run lengths are parameters. Their defaults are 15 and 25 ticks and 3 and 5 cycles.

Top module: `pll_lock_watch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `locked` to 0 and empties the run of clean cycles.
- R2: With `five_mode` at 0 and lock absent, `locked` rises at the clock edge that registers the third consecutive strobe whose `pd_err` is strictly below LOCK_TH (default 15). It stays low after only two such strobes.
- R3: With `five_mode` at 1 and lock absent, `locked` rises at the edge that registers the fifth consecutive clean strobe. It stays low after four.
- R4: While lock is absent, a strobe with `pd_err` at or above LOCK_TH empties the run, so counting restarts from zero.
- R5: While locked, a strobe with `pd_err` from LOCK_TH up to and including UNLOCK_TH (default 25) leaves `locked` high.
- R6: While locked, a strobe with `pd_err` strictly above UNLOCK_TH clears `locked` at the edge that registers it. The run is emptied, so regaining lock needs the full count of clean strobes again.
- R7: Clock cycles without a strobe (`pd_valid` low) change neither `locked` nor the run, whatever `pd_err` and `five_mode` carry.
- R8: The count needed is taken from `five_mode` as sampled on each strobe. A run of three clean strobes locks if the third one carries mode 0, even when the earlier ones carried mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_valid | input | 1 | One-cycle strobe marking one phase-detector cycle |
| pd_err | input | ERR_W (8) | Phase-error magnitude for this cycle, in clock ticks |
| five_mode | input | 1 | 0: three clean cycles needed; 1: five needed |
| locked | output | 1 | Active-high lock indication |

## Verification
A wrong internal run count shows at the `locked` port as lock rising one or more strobes early or late. It is visible at the first clock edge after the completing strobe. A run that is not emptied on a dirty cycle or on release shows as lock returning too soon after an error. A lock flag that ignores the release threshold shows up at the edge right after the first strobe above UNLOCK_TH. The bench sweeps every clean/dirty pattern of six strobes in both modes, and sweeps the error value across both thresholds, so each of these faults reaches a check within a few strobes.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
    // Classification of one phase-detector cycle's error.
    typedef enum logic [1:0] {
        GR_CLEAN = 2'd0,   // below the acquisition threshold
        GR_MID   = 2'd1,   // between the two thresholds (inclusive of both)
        GR_LOSS  = 2'd2    // above the release threshold
    } grade_t;
endpackage

// File: rtl/lockdet_grade.sv
module lockdet_grade
    import lockdet_pkg::*;
#(
    parameter int ERR_W     = 8,
    parameter int LOCK_TH   = 15,
    parameter int UNLOCK_TH = 25
) (
    input  logic [ERR_W-1:0] err,
    output grade_t           grade
);
    localparam logic [ERR_W-1:0] ACQ_LIM = ERR_W'(LOCK_TH);
    localparam logic [ERR_W-1:0] REL_LIM = ERR_W'(UNLOCK_TH);

    always_comb begin
        if (err < ACQ_LIM) begin
            grade = GR_CLEAN;
        end else if (err > REL_LIM) begin
            grade = GR_LOSS;
        end else begin
            grade = GR_MID;
        end
    end
endmodule

// File: rtl/lockdet_need.sv
module lockdet_need #(
    parameter int CNT_LO = 3,
    parameter int CNT_HI = 5,
    parameter int CW     = 3
) (
    input  logic          sel_hi,
    output logic [CW-1:0] need
);
    localparam logic [CW-1:0] NEED_LO = CW'(CNT_LO);
    localparam logic [CW-1:0] NEED_HI = CW'(CNT_HI);

    generate
        if (CNT_LO == CNT_HI) begin : g_fixed
            assign need = NEED_LO;
        end else begin : g_sel
            assign need = sel_hi ? NEED_HI : NEED_LO;
        end
    endgenerate

    logic unused_sel;
    assign unused_sel = sel_hi;
endmodule

// File: rtl/lockdet_core.sv
module lockdet_core
    import lockdet_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  grade_t        grade,
    input  logic [CW-1:0] need,
    output logic          locked
);
    typedef struct packed {
        logic          locked;
        logic [CW-1:0] run;
    } state_t;

    state_t st_d, st_q;
    logic [CW:0] run_inc;

    always_comb begin
        st_d    = st_q;
        run_inc = {1'b0, st_q.run} + (CW+1)'(1);
        if (strobe) begin
            if (!st_q.locked) begin
                if (grade == GR_CLEAN) begin
                    if (run_inc >= {1'b0, need}) begin
                        st_d.locked = 1'b1;
                        st_d.run    = '0;
                    end else begin
                        st_d.run    = run_inc[CW-1:0];
                    end
                end else begin
                    st_d.run = '0;
                end
            end else if (grade == GR_LOSS) begin
                st_d.locked = 1'b0;
                st_d.run    = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;
endmodule

// File: rtl/pll_lock_watch.sv
module pll_lock_watch
    import lockdet_pkg::*;
#(
    parameter int ERR_W     = 8,
    parameter int LOCK_TH   = 15,
    parameter int UNLOCK_TH = 25,
    parameter int CNT_LO    = 3,
    parameter int CNT_HI    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_valid,
    input  logic [ERR_W-1:0] pd_err,
    input  logic             five_mode,
    output logic             locked
);
    localparam int CNT_MAX = (CNT_HI > CNT_LO) ? CNT_HI : CNT_LO;
    localparam int CW      = $clog2(CNT_MAX + 1);

    grade_t        grade;
    logic [CW-1:0] need;

    lockdet_grade #(
        .ERR_W(ERR_W), .LOCK_TH(LOCK_TH), .UNLOCK_TH(UNLOCK_TH)
    ) u_grade (
        .err(pd_err), .grade(grade)
    );

    lockdet_need #(
        .CNT_LO(CNT_LO), .CNT_HI(CNT_HI), .CW(CW)
    ) u_need (
        .sel_hi(five_mode), .need(need)
    );

    lockdet_core #(
        .CW(CW)
    ) u_core (
        .clk(clk), .rst(rst), .strobe(pd_valid),
        .grade(grade), .need(need), .locked(locked)
    );
endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk #(
    parameter int ERR_W     = 8,
    parameter int LOCK_TH   = 15,
    parameter int UNLOCK_TH = 25,
    parameter int CNT_LO    = 3,
    parameter int CNT_HI    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             pd_valid,
    input logic [ERR_W-1:0] pd_err,
    input logic             five_mode,
    input logic             locked
);
    localparam logic [ERR_W-1:0] ACQ_LIM = ERR_W'(LOCK_TH);
    localparam logic [ERR_W-1:0] REL_LIM = ERR_W'(UNLOCK_TH);
    localparam int RW = $clog2(CNT_HI + CNT_LO + 2);
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};

    // Independent count of consecutive clean strobes seen while unlocked.
    logic [RW-1:0] ck_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_run <= '0;
        end else if (pd_valid) begin
            if (locked || pd_err >= ACQ_LIM) begin
                ck_run <= '0;
            end else if (ck_run != RMAX) begin
                ck_run <= ck_run + RW'(1);
            end
        end
    end

    // R1
    p_reset_clears_r1: assert property (@(posedge clk) rst |=> !locked);

    // R2, R3, R8: lock only after the count chosen by the completing strobe's mode
    p_count_met_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (ck_run >= ($past(five_mode) ? RW'(CNT_HI) : RW'(CNT_LO))));

    // R4: lock only ever rises on a clean strobe
    p_rise_on_clean_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(pd_valid && pd_err < ACQ_LIM));

    // R5
    p_hold_mid_r5: assert property (@(posedge clk) disable iff (rst)
        (locked && pd_valid && pd_err <= REL_LIM) |=> locked);

    // R6
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && pd_valid && pd_err > REL_LIM) |=> !locked);

    // R7
    p_idle_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !pd_valid |=> $stable(locked));
endmodule

bind pll_lock_watch lockdet_chk #(
    .ERR_W(ERR_W), .LOCK_TH(LOCK_TH), .UNLOCK_TH(UNLOCK_TH),
    .CNT_LO(CNT_LO), .CNT_HI(CNT_HI)
) u_chk (
    .clk(clk), .rst(rst), .pd_valid(pd_valid), .pd_err(pd_err),
    .five_mode(five_mode), .locked(locked)
);

// File: tb/pll_lock_watch_test.sv
module pll_lock_watch_test;
    localparam int ERR_W = 8;
    localparam int LTH   = 15;
    localparam int UTH   = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_valid = 1'b0;
    logic [ERR_W-1:0] pd_err = '0;
    logic five_mode = 1'b0;
    logic locked;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // bench-side expectation
    bit m_lock;
    int m_run;

    always #5 clk = ~clk;

    pll_lock_watch #(.ERR_W(ERR_W), .LOCK_TH(LTH), .UNLOCK_TH(UTH),
                     .CNT_LO(3), .CNT_HI(5)) uut (
        .clk(clk), .rst(rst), .pd_valid(pd_valid), .pd_err(pd_err),
        .five_mode(five_mode), .locked(locked));

    task automatic check(input string tag, input logic exp);
        n_checks++;
        if (locked !== exp) begin
            n_errors++;
            $display("FAIL %s: locked=%b expected=%b at %0t", tag, locked, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pd_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_lock = 1'b0; m_run = 0;
    endtask

    // one strobe; expectation updated arithmetically from the requirements
    task automatic strobe(input int e, input bit m);
        int need;
        @(negedge clk);
        pd_valid = 1'b1; pd_err = ERR_W'(e); five_mode = m;
        @(negedge clk);
        pd_valid = 1'b0; pd_err = 8'hFF; five_mode = ~m;
        need = m ? 5 : 3;
        if (!m_lock) begin
            if (e < LTH) begin
                m_run = m_run + 1;
                if (m_run >= need) begin m_lock = 1'b1; m_run = 0; end
            end else m_run = 0;
        end else if (e > UTH) begin
            m_lock = 1'b0; m_run = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 reset", 1'b0);

        // R1: reset mid-run empties the run
        strobe(0, 0); strobe(0, 0);
        do_reset();
        strobe(0, 0); strobe(0, 0);
        check("R1 run emptied by reset", 1'b0);
        strobe(0, 0);
        check("R1 full count after reset", 1'b1);
        do_reset();
        check("R1 reset drops lock", 1'b0);

        // R2/R3: k clean strobes per mode
        for (int md = 0; md < 2; md++) begin
            for (int k = 1; k <= 6; k++) begin
                do_reset();
                for (int i = 0; i < k; i++) strobe((i * 4) % LTH, md[0]);
                check(md == 0 ? "R2 clean run" : "R3 clean run",
                      k >= (md == 0 ? 3 : 5));
            end
        end

        // R4/R5: every 6-strobe clean/dirty pattern in both modes
        for (int md = 0; md < 2; md++) begin
            for (int p = 0; p < 64; p++) begin
                do_reset();
                for (int i = 0; i < 6; i++) begin
                    if (p[i]) strobe((p + i) % LTH, md[0]);
                    else      strobe(LTH + (p + i) % (UTH - LTH + 1), md[0]);
                    check("R4 R5 pattern", m_lock);
                end
                // R6: release from whatever state
                strobe(UTH + 1 + p % 30, md[0]);
                check("R6 pattern release", 1'b0);
            end
        end

        // R4/R5/R6: error sweep at the boundaries
        for (int e = 0; e <= 40; e++) begin
            do_reset();
            strobe(0, 0); strobe(0, 0); strobe(e, 0); strobe(0, 0);
            check("R4 sweep unlocked", e < LTH);
            do_reset();
            strobe(0, 0); strobe(0, 0); strobe(0, 0); strobe(e, 0);
            check(e > UTH ? "R6 sweep locked" : "R5 sweep locked", e <= UTH);
        end

        // R6: reacquisition needs the full count
        do_reset();
        strobe(0, 1); strobe(0, 1); strobe(0, 1); strobe(0, 1); strobe(0, 1);
        check("R3 lock before release", 1'b1);
        strobe(UTH + 1, 1);
        check("R6 release", 1'b0);
        for (int i = 0; i < 4; i++) strobe(1, 1);
        check("R6 four after release", 1'b0);
        strobe(1, 1);
        check("R6 fifth after release", 1'b1);

        // R7: idle cycles with wild inputs
        repeat (10) begin
            @(negedge clk); pd_err = 8'hFF; five_mode = ~five_mode;
        end
        @(negedge clk);
        check("R7 idle keeps lock", 1'b1);
        do_reset();
        strobe(0, 0); strobe(0, 0);
        repeat (8) begin
            @(negedge clk); pd_err = 8'd200; five_mode = 1'b1;
        end
        @(negedge clk);
        check("R7 idle no lock", 1'b0);
        strobe(0, 0);
        check("R7 run kept over idle", 1'b1);

        // R8: mode taken from the completing strobe
        do_reset();
        strobe(0, 1); strobe(0, 1);
        check("R8 two in mode 1", 1'b0);
        strobe(0, 0);
        check("R8 third in mode 0 locks", 1'b1);
        do_reset();
        strobe(0, 0); strobe(0, 0); strobe(0, 1);
        check("R8 third in mode 1 waits", 1'b0);
        strobe(0, 1); strobe(0, 1);
        check("R8 fifth in mode 1", 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule